// File: doc/BRIEF.md
# Two-Ring Transmit Descriptor Fetch Engine

This block pulls outgoing frames from host memory for an Ethernet transmitter. Software builds descriptors in two circular rings, an urgent ring and a bulk ring. Each descriptor names one buffer fragment. Software then pulses the poll input for a ring. The engine walks the ring and collects every fragment of a frame, from the one flagged as first to the one flagged as last. It fetches the bytes through a 32-bit read port and streams them, one byte per handshake, to a MAC that appends the 4-byte CRC. Frames below the Ethernet minimum get zero bytes appended, so the MAC always receives at least 60 data bytes.

When a frame is finished, the engine returns its descriptors to software by rewriting word 0 of each one with the ownership bit cleared. A ring goes quiet when it meets a descriptor that software still holds. It stays quiet until its poll input pulses again. Malformed frames and misaligned ring bases raise a one-cycle error pulse and are skipped.

Top module: `txdesc_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, `tx_valid_o`, `mem_req_valid_o` and `err_o` are low.
- R2: The descriptor at ring index i occupies four 32-bit words at base + 16*i. Word 0 holds the fields: bit 31 = owned by engine, bit 30 = end of ring, bit 29 = first fragment, bit 28 = last fragment, bits 15:0 = byte length. Word 2 holds the byte address of the buffer. Buffer bytes leave in address order, and byte lane k of a memory word is bits 8k+7:8k.
- R3: At each frame boundary the urgent ring is served before the bulk ring. A frame already started is never interrupted, even when the urgent ring is polled during it.
- R4: The fragments from a first-flagged descriptor through the next last-flagged one form one frame. `tx_sof_o` marks its first byte and `tx_eof_o` its last byte.
- R5: A frame whose fragments total fewer than 60 bytes is followed by zero bytes up to exactly 60 bytes. Longer frames pass unchanged.
- R6: After a frame, each of its descriptors has word 0 rewritten with bit 31 cleared and every other bit as fetched.
- R7: After a descriptor with the end-of-ring bit, the next fetch from that ring uses index 0.
- R8: A ring whose next descriptor has bit 31 clear emits nothing further until its poll input pulses again. Work then resumes at that same descriptor.
- R9: The following raise a one-cycle `err_o` pulse and send no bytes: a buffer length below 4, a frame whose first descriptor lacks the first-fragment bit, or a ring base whose low 8 bits are not zero. For the first two cases the descriptors are still returned as in R6. A misaligned ring is not read until it is polled again.
- R10: While `tx_valid_o` is high and `tx_ready_i` low, `tx_data_o` holds. While `mem_req_valid_o` is high and `mem_req_ready_i` low, the request holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hi_base_i | input | 32 | Urgent ring base byte address |
| lo_base_i | input | 32 | Bulk ring base byte address |
| hi_poll_i | input | 1 | Pulse: urgent ring has new work |
| lo_poll_i | input | 1 | Pulse: bulk ring has new work |
| mem_req_valid_o | output | 1 | Memory request present |
| mem_req_write_o | output | 1 | 1 = write, 0 = read |
| mem_req_addr_o | output | 32 | Word-aligned byte address |
| mem_req_wdata_o | output | 32 | Write data |
| mem_req_ready_i | input | 1 | Memory accepts request |
| mem_rsp_valid_i | input | 1 | Read data returned (in order) |
| mem_rsp_data_i | input | 32 | Read data |
| tx_valid_o | output | 1 | Output byte present |
| tx_data_o | output | 8 | Output byte |
| tx_sof_o | output | 1 | First byte of frame |
| tx_eof_o | output | 1 | Last byte of frame |
| tx_ready_i | input | 1 | MAC takes the byte |
| err_o | output | 1 | One-cycle error pulse |

## Verification
The bench places buffers at odd byte offsets and chains fragments as short as 4 bytes. A design that mishandles lane selection would reorder or drop bytes. The bench polls both rings in the same cycle, and also polls the urgent ring in the middle of a long bulk frame. A design that preempts would split that frame or reorder frames. Rings are driven across their end-of-ring slot, and descriptors are checked after writeback. A design that wraps wrongly or clobbers fields would be caught there. Length-2 buffers, a missing first flag, an unaligned base and a descriptor that was never polled check that bad or unannounced work produces an error pulse, or silence, rather than output.

// File: rtl/txd_pkg.sv
// Shared types and descriptor field positions for the transmit descriptor engine.
// Assumes descriptors are four 32-bit words with control in word 0 and address in word 2.
package txd_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_DREQ, ST_DRSP, ST_AREQ, ST_ARSP,
        ST_BREQ, ST_BRSP, ST_PAD, ST_WB
    } txd_state_t;

    localparam int OWN_BIT = 31;
    localparam int EOR_BIT = 30;
    localparam int FS_BIT  = 29;
    localparam int LS_BIT  = 28;
    localparam int RING_HI = 0;
    localparam int RING_LO = 1;
endpackage

// File: rtl/txd_ring_ctrl.sv
// Per-ring bookkeeping: committed head index and a pending-work flag.
// Assumes poll, stall and commit are single-cycle pulses from the fetch engine.
// A poll in the same cycle as a stall wins, so a late software update is never lost.
module txd_ring_ctrl #(
    parameter int IDXW = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [7:0]      base_lo_i,
    input  logic            poll_i,
    input  logic            stall_i,
    input  logic            commit_i,
    input  logic [IDXW-1:0] commit_idx_i,
    output logic [IDXW-1:0] head_o,
    output logic            pend_o,
    output logic            base_ok_o
);
    // Ring base must sit on a 256-byte boundary.
    assign base_ok_o = (base_lo_i == 8'h00);

    // Head moves only when a whole frame has been returned to software.
    always_ff @(posedge clk) begin
        if (!rst_n)        head_o <= '0;
        else if (commit_i) head_o <= commit_idx_i;
    end

    // Pending is set by a poll and cleared when the engine finds no owned descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n)       pend_o <= 1'b0;
        else if (poll_i)  pend_o <= 1'b1;
        else if (stall_i) pend_o <= 1'b0;
    end

    // R8
    poll_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        poll_i |=> pend_o);
    // R8
    stall_clears_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_i && !poll_i) |=> !pend_o);
endmodule

// File: rtl/txd_unpack.sv
// Turns one loaded memory word into 1..4 output bytes starting at a given lane.
// Assumes it is loaded only while idle. Frame markers apply to the first and last byte of the load.
module txd_unpack (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load_i,
    input  logic [31:0] word_i,
    input  logic [1:0]  lane_i,
    input  logic [2:0]  cnt_i,
    input  logic        sof_i,
    input  logic        eof_i,
    output logic        busy_o,
    output logic        tx_valid_o,
    output logic [7:0]  tx_data_o,
    output logic        tx_sof_o,
    output logic        tx_eof_o,
    input  logic        tx_ready_i
);
    logic [31:0] word_q;
    logic [1:0]  lane_q;
    logic [2:0]  left_q;
    logic        first_q, sof_q, eof_q;

    assign tx_valid_o = (left_q != 3'd0);
    assign busy_o     = tx_valid_o;
    assign tx_sof_o   = tx_valid_o && sof_q && first_q;
    assign tx_eof_o   = tx_valid_o && eof_q && (left_q == 3'd1);

    // Select the byte lane currently being presented.
    always_comb begin
        case (lane_q)
            2'd0:    tx_data_o = word_q[7:0];
            2'd1:    tx_data_o = word_q[15:8];
            2'd2:    tx_data_o = word_q[23:16];
            default: tx_data_o = word_q[31:24];
        endcase
    end

    // Load a word, then step through its lanes on each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0; lane_q <= '0; left_q <= '0;
            first_q <= 1'b0; sof_q <= 1'b0; eof_q <= 1'b0;
        end else if (load_i) begin
            word_q <= word_i; lane_q <= lane_i; left_q <= cnt_i;
            first_q <= 1'b1; sof_q <= sof_i; eof_q <= eof_i;
        end else if (tx_valid_o && tx_ready_i) begin
            lane_q  <= lane_q + 2'd1;
            left_q  <= left_q - 3'd1;
            first_q <= 1'b0;
        end
    end

    // R10
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));
    // R4
    load_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !busy_o);
endmodule

// File: rtl/txdesc_engine.sv
// Two-ring transmit descriptor engine. It fetches descriptor chains and checks them,
// streams buffer bytes with padding to a minimum frame, then clears ownership.
// Assumes in-order read responses, one outstanding request, and ring bases stable while in use.
// Frame fragments are held locally (MAX_FRAGS), so a longer chain is split and flagged.
module txdesc_engine
    import txd_pkg::*;
#(
    parameter int RING_DEPTH = 1024,
    parameter int MAX_FRAGS  = 8,
    parameter int MIN_DATA   = 60
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] hi_base_i,
    input  logic [31:0] lo_base_i,
    input  logic        hi_poll_i,
    input  logic        lo_poll_i,
    output logic        mem_req_valid_o,
    output logic        mem_req_write_o,
    output logic [31:0] mem_req_addr_o,
    output logic [31:0] mem_req_wdata_o,
    input  logic        mem_req_ready_i,
    input  logic        mem_rsp_valid_i,
    input  logic [31:0] mem_rsp_data_i,
    output logic        tx_valid_o,
    output logic [7:0]  tx_data_o,
    output logic        tx_sof_o,
    output logic        tx_eof_o,
    input  logic        tx_ready_i,
    output logic        err_o
);
    localparam int IDXW = $clog2(RING_DEPTH);
    localparam int PW   = (MAX_FRAGS > 2) ? $clog2(MAX_FRAGS) : 1;
    localparam int FW   = $clog2(MAX_FRAGS + 1);
    localparam int SW   = 16 + PW + 1;

    // Ring-side wiring, index RING_HI / RING_LO.
    logic [31:0]     base_a [2];
    logic [1:0]      poll_a, stall_c, commit_c, pend_a, ok_a;
    logic [IDXW-1:0] head_a [2];

    // Engine state.
    txd_state_t      st;
    logic            sel;
    logic [IDXW-1:0] fidx, sidx, widx;
    logic [FW-1:0]   nfrag, wi;
    logic [PW-1:0]   fi;
    logic            bad;
    logic [31:0]     w0_q [MAX_FRAGS];
    logic [31:0]     ad_q [MAX_FRAGS];
    logic [31:0]     ptr;
    logic [15:0]     rem;
    logic [SW-1:0]   sent;

    assign base_a[RING_HI] = hi_base_i;
    assign base_a[RING_LO] = lo_base_i;
    assign poll_a          = {lo_poll_i, hi_poll_i};

    generate
        for (genvar g = 0; g < 2; g++) begin : g_ring
            txd_ring_ctrl #(.IDXW(IDXW)) u_ring (
                .clk(clk), .rst_n(rst_n), .base_lo_i(base_a[g][7:0]),
                .poll_i(poll_a[g]), .stall_i(stall_c[g]), .commit_i(commit_c[g]),
                .commit_idx_i(fidx), .head_o(head_a[g]), .pend_o(pend_a[g]),
                .base_ok_o(ok_a[g]));
        end
    endgenerate

    function automatic logic [IDXW-1:0] step_idx(input logic [IDXW-1:0] i, input logic eor);
        return (eor || i == IDXW'(RING_DEPTH - 1)) ? '0 : i + 1'b1;
    endfunction

    function automatic logic [31:0] desc_at(input logic [31:0] b, input logic [IDXW-1:0] i);
        return b + {{(28 - IDXW){1'b0}}, i, 4'b0000};
    endfunction

    // Derived per-cycle values.
    logic          go, pick, accept, busy;
    logic [PW-1:0] slot, wslot;
    logic [2:0]    avail, chunk, pad_n;
    logic          last_frag, last_chunk, chunk_eof, pad_last, last_wb;
    logic [SW-1:0] sent_n, pad_need;
    logic [31:0]   cur_base;

    assign go       = |pend_a;
    assign pick     = pend_a[RING_HI] ? 1'(RING_HI) : 1'(RING_LO);
    assign accept   = mem_req_valid_o && mem_req_ready_i;
    assign slot     = nfrag[PW-1:0];
    assign wslot    = wi[PW-1:0];
    assign cur_base = base_a[sel];

    // Fragment chunking and padding arithmetic.
    always_comb begin
        avail      = 3'd4 - {1'b0, ptr[1:0]};
        chunk      = (rem < 16'(avail)) ? rem[2:0] : avail;
        last_frag  = (FW'(fi) + FW'(1)) == nfrag;
        last_chunk = last_frag && (rem == 16'(chunk));
        sent_n     = sent + SW'(chunk);
        chunk_eof  = last_chunk && (sent_n >= SW'(MIN_DATA));
        pad_need   = SW'(MIN_DATA) - sent;
        pad_last   = pad_need <= SW'(4);
        pad_n      = pad_last ? pad_need[2:0] : 3'd4;
        last_wb    = (wi + FW'(1)) == nfrag;
    end

    // Memory request generation per state.
    always_comb begin
        mem_req_valid_o = 1'b0;
        mem_req_write_o = 1'b0;
        mem_req_addr_o  = '0;
        mem_req_wdata_o = '0;
        case (st)
            ST_DREQ: begin
                mem_req_valid_o = 1'b1;
                mem_req_addr_o  = desc_at(cur_base, fidx);
            end
            ST_AREQ: begin
                mem_req_valid_o = 1'b1;
                mem_req_addr_o  = desc_at(cur_base, fidx) + 32'd8;
            end
            ST_BREQ: begin
                mem_req_valid_o = !busy;
                mem_req_addr_o  = {ptr[31:2], 2'b00};
            end
            ST_WB: begin
                mem_req_valid_o = 1'b1;
                mem_req_write_o = 1'b1;
                mem_req_addr_o  = desc_at(cur_base, widx);
                mem_req_wdata_o = w0_q[wslot] & ~(32'd1 << OWN_BIT);
            end
            default: ;
        endcase
    end

    // Ring stall and commit pulses.
    always_comb begin
        stall_c  = '0;
        commit_c = '0;
        if (st == ST_IDLE && go && !ok_a[pick])                       stall_c[pick] = 1'b1;
        if (st == ST_DRSP && mem_rsp_valid_i && !mem_rsp_data_i[OWN_BIT]) stall_c[sel] = 1'b1;
        if (st == ST_WB && accept && last_wb)                          commit_c[sel] = 1'b1;
    end

    // Unpacker load: buffer data on a read response, zeros while padding.
    logic        ld, ld_sof, ld_eof;
    logic [31:0] ld_word;
    logic [1:0]  ld_lane;
    logic [2:0]  ld_cnt;
    always_comb begin
        ld      = (st == ST_BRSP) && mem_rsp_valid_i;
        ld_word = mem_rsp_data_i;
        ld_lane = ptr[1:0];
        ld_cnt  = chunk;
        ld_sof  = (sent == '0);
        ld_eof  = chunk_eof;
        if (st == ST_PAD) begin
            ld      = !busy;
            ld_word = '0;
            ld_lane = 2'd0;
            ld_cnt  = pad_n;
            ld_sof  = 1'b0;
            ld_eof  = pad_last;
        end
    end

    txd_unpack u_unpack (
        .clk(clk), .rst_n(rst_n), .load_i(ld), .word_i(ld_word), .lane_i(ld_lane),
        .cnt_i(ld_cnt), .sof_i(ld_sof), .eof_i(ld_eof), .busy_o(busy),
        .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o), .tx_sof_o(tx_sof_o),
        .tx_eof_o(tx_eof_o), .tx_ready_i(tx_ready_i));

    // Descriptor fragment store, filled as each descriptor arrives.
    always_ff @(posedge clk) begin
        if (st == ST_DRSP && mem_rsp_valid_i && mem_rsp_data_i[OWN_BIT]) w0_q[slot] <= mem_rsp_data_i;
        if (st == ST_ARSP && mem_rsp_valid_i)                         ad_q[slot] <= mem_rsp_data_i;
    end

    // Main sequencer: select ring, gather chain, stream bytes, pad, release descriptors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE; sel <= 1'b0; fidx <= '0; sidx <= '0; widx <= '0;
            nfrag <= '0; wi <= '0; fi <= '0; bad <= 1'b0;
            ptr <= '0; rem <= '0; sent <= '0; err_o <= 1'b0;
        end else begin
            err_o <= 1'b0;
            case (st)
                ST_IDLE: if (go) begin
                    if (!ok_a[pick]) begin
                        err_o <= 1'b1;
                    end else begin
                        sel <= pick; fidx <= head_a[pick]; sidx <= head_a[pick];
                        nfrag <= '0; bad <= 1'b0; st <= ST_DREQ;
                    end
                end
                ST_DREQ: if (accept) st <= ST_DRSP;
                ST_DRSP: if (mem_rsp_valid_i) begin
                    if (!mem_rsp_data_i[OWN_BIT]) begin
                        st <= ST_IDLE;
                    end else begin
                        if ((nfrag == '0 && !mem_rsp_data_i[FS_BIT]) || mem_rsp_data_i[15:0] < 16'd4)
                            bad <= 1'b1;
                        st <= ST_AREQ;
                    end
                end
                ST_AREQ: if (accept) st <= ST_ARSP;
                ST_ARSP: if (mem_rsp_valid_i) begin
                    nfrag <= nfrag + FW'(1);
                    fidx  <= step_idx(fidx, w0_q[slot][EOR_BIT]);
                    if (w0_q[slot][LS_BIT] || nfrag == FW'(MAX_FRAGS - 1)) begin
                        if (bad || !w0_q[slot][LS_BIT]) begin
                            err_o <= 1'b1; wi <= '0; widx <= sidx; st <= ST_WB;
                        end else begin
                            fi   <= '0;
                            ptr  <= (nfrag == '0) ? mem_rsp_data_i : ad_q[0];
                            rem  <= w0_q[0][15:0];
                            sent <= '0;
                            st   <= ST_BREQ;
                        end
                    end else begin
                        st <= ST_DREQ;
                    end
                end
                ST_BREQ: if (accept) st <= ST_BRSP;
                ST_BRSP: if (mem_rsp_valid_i) begin
                    ptr  <= ptr + 32'(chunk);
                    rem  <= rem - 16'(chunk);
                    sent <= sent_n;
                    st   <= ST_BREQ;
                    if (rem == 16'(chunk)) begin
                        if (last_frag) begin
                            if (chunk_eof) begin
                                wi <= '0; widx <= sidx; st <= ST_WB;
                            end else begin
                                st <= ST_PAD;
                            end
                        end else begin
                            fi  <= fi + 1'b1;
                            ptr <= ad_q[fi + 1'b1];
                            rem <= w0_q[fi + 1'b1][15:0];
                        end
                    end
                end
                ST_PAD: if (!busy) begin
                    sent <= sent + SW'(pad_n);
                    if (pad_last) begin
                        wi <= '0; widx <= sidx; st <= ST_WB;
                    end
                end
                ST_WB: if (accept) begin
                    widx <= step_idx(widx, w0_q[wslot][EOR_BIT]);
                    wi   <= wi + FW'(1);
                    if (last_wb) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Byte position within the current frame, kept for the checks below.
    logic [SW-1:0] frame_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)                         frame_cnt <= '0;
        else if (tx_valid_o && tx_ready_i)  frame_cnt <= tx_eof_o ? '0 : frame_cnt + SW'(1);
    end

    // R5
    min_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && tx_ready_i && tx_eof_o) |-> (frame_cnt >= SW'(MIN_DATA - 1)));
    // R4
    sof_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && tx_ready_i && tx_sof_o) |-> (frame_cnt == '0));
    // R6
    wb_own_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid_o && mem_req_write_o) |-> !mem_req_wdata_o[OWN_BIT]);
    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid_o && !mem_req_ready_i) |=>
            (mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_write_o)));
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (!tx_valid_o && !mem_req_valid_o && !err_o));
endmodule

// File: tb/txdesc_engine_tb.sv
module txdesc_engine_tb;
    localparam logic [31:0] HB = 32'h100;
    localparam logic [31:0] LB = 32'h200;
    localparam logic [31:0] OWN = 32'h8000_0000, EOR = 32'h4000_0000;
    localparam logic [31:0] FS = 32'h2000_0000, LS = 32'h1000_0000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [31:0] hi_base = HB, lo_base = LB;
    logic hi_poll = 1'b0, lo_poll = 1'b0;
    logic req_v, req_w, req_rdy = 1'b0, rsp_v = 1'b0;
    logic [31:0] req_a, req_d, rsp_d = '0;
    logic tx_v, tx_sof, tx_eof, tx_rdy = 1'b0, err;
    logic [7:0] tx_d;

    always #2 clk = ~clk;

    txdesc_engine u_dut (
        .clk(clk), .rst_n(rst_n), .hi_base_i(hi_base), .lo_base_i(lo_base),
        .hi_poll_i(hi_poll), .lo_poll_i(lo_poll), .mem_req_valid_o(req_v),
        .mem_req_write_o(req_w), .mem_req_addr_o(req_a), .mem_req_wdata_o(req_d),
        .mem_req_ready_i(req_rdy), .mem_rsp_valid_i(rsp_v), .mem_rsp_data_i(rsp_d),
        .tx_valid_o(tx_v), .tx_data_o(tx_d), .tx_sof_o(tx_sof), .tx_eof_o(tx_eof),
        .tx_ready_i(tx_rdy), .err_o(err));

    logic [31:0] mem [0:4095];
    int nchk = 0, nerr = 0, errs = 0, cur_len = 0, sl [2], bufp = 32'h1000;
    logic [7:0] got_b [$], exp_b [$], xb [2][$];
    int got_l [$], exp_l [$], xl [2][$], wb_a [$];
    logic [31:0] wb_v [$];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Memory and MAC responder: drives inputs at the falling edge, records traffic.
    initial begin
        bit rd_pend = 0, hold = 0;
        logic [31:0] rd_a = '0;
        logic [7:0] hold_d = '0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                req_rdy = 0; rsp_v = 0; tx_rdy = 0; rd_pend = 0; hold = 0;
            end else begin
                rsp_v = rd_pend;
                rsp_d = rd_pend ? mem[rd_a[13:2]] : '0;
                rd_pend = 0;
                if (hold) chk(tx_v && tx_d == hold_d, "R10 byte hold", {23'd0, tx_v, tx_d}, {24'd1, hold_d});
                req_rdy = ($urandom % 4) != 0;
                if (req_v && req_rdy) begin
                    if (req_w) mem[req_a[13:2]] = req_d;
                    else begin rd_pend = 1; rd_a = req_a; end
                end
                tx_rdy = ($urandom % 3) != 0;
                hold = tx_v && !tx_rdy;
                hold_d = tx_d;
                if (tx_v && tx_rdy) begin
                    if (tx_sof && cur_len != 0) chk(0, "R4 sof mid-frame", cur_len, 0);
                    got_b.push_back(tx_d);
                    cur_len++;
                    if (tx_eof) begin got_l.push_back(cur_len); cur_len = 0; end
                end
                if (err) errs++;
            end
        end
    end

    task automatic put_desc(input int r, input logic [31:0] flags, input int len, input logic [31:0] a);
        logic [31:0] w0 = flags | ((sl[r] == 7) ? EOR : 32'd0) | 32'(len[15:0]);
        int wa = ((r == 0 ? HB : LB) + 32'(sl[r] * 16)) >> 2;
        mem[wa] = w0; mem[wa + 2] = a;
        wb_a.push_back(wa); wb_v.push_back(w0 & ~OWN);
        sl[r] = (sl[r] + 1) % 8;
    endtask

    task automatic put_pkt(input int r, input int nfr, input int lens [3], input int offs [3]);
        logic [7:0] fb [$];
        for (int f = 0; f < nfr; f++) begin
            int a;
            if (bufp > 32'h3E00) bufp = 32'h1000;
            a = bufp + offs[f];
            bufp = (a + lens[f] + 8) & ~7;
            for (int i = 0; i < lens[f]; i++) begin
                logic [7:0] b = 8'($urandom);
                mem[(a + i) >> 2][8 * ((a + i) % 4) +: 8] = b;
                fb.push_back(b);
            end
            put_desc(r, OWN | (f == 0 ? FS : 32'd0) | (f == nfr - 1 ? LS : 32'd0), lens[f], a);
        end
        while (fb.size() < 60) fb.push_back(8'h00);
        foreach (fb[i]) xb[r].push_back(fb[i]);
        xl[r].push_back(fb.size());
    endtask

    task automatic take(input int r);
        foreach (xb[r][i]) exp_b.push_back(xb[r][i]);
        foreach (xl[r][i]) exp_l.push_back(xl[r][i]);
        xb[r].delete(); xl[r].delete();
    endtask

    task automatic poll(input bit h, input bit l);
        @(negedge clk); hi_poll = h; lo_poll = l;
        @(negedge clk); hi_poll = 0; lo_poll = 0;
    endtask

    task automatic check_frames(input string tag);
        int t = 0, off = 0;
        while (got_l.size() < exp_l.size() && t < 20000) begin @(negedge clk); t++; end
        repeat (80) @(negedge clk);
        chk(got_l.size() == exp_l.size(), {tag, " frame count"}, got_l.size(), exp_l.size());
        for (int f = 0; f < exp_l.size() && f < got_l.size(); f++) begin
            int bad = 0;
            chk(got_l[f] == exp_l[f], {tag, " frame length"}, got_l[f], exp_l[f]);
            for (int i = 0; i < exp_l[f] && off + i < got_b.size(); i++)
                if (got_b[off + i] != exp_b[off + i]) bad++;
            chk(bad == 0, {tag, " frame bytes"}, bad, 0);
            off += exp_l[f];
        end
        got_b.delete(); got_l.delete(); exp_b.delete(); exp_l.delete();
    endtask

    task automatic check_own(input string tag);
        foreach (wb_a[i]) chk(mem[wb_a[i]] == wb_v[i], {tag, " word0 writeback"}, mem[wb_a[i]], wb_v[i]);
        wb_a.delete(); wb_v.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        int e0, t;
        void'($urandom(32'd1234));
        foreach (mem[i]) mem[i] = '0;
        sl[0] = 0; sl[1] = 0;
        repeat (4) @(negedge clk);
        chk(!tx_v && !req_v && !err, "R1 reset outputs", {tx_v, req_v, err}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(!tx_v && !req_v && !err, "R1 after reset", {tx_v, req_v, err}, 0);

        // R5 R2: short single buffer at odd offset
        put_pkt(1, 1, '{10, 0, 0}, '{3, 0, 0}); take(1); poll(0, 1);
        check_frames("R5 pad"); check_own("R6");

        // R4 R2: three-fragment chain on urgent ring
        put_pkt(0, 3, '{30, 4, 50}, '{1, 2, 0}); take(0); poll(0, 1'b0); poll(1, 0);
        check_frames("R4 chain"); check_own("R6");

        // R3: both rings polled together
        put_pkt(1, 1, '{20, 0, 0}, '{0, 0, 0}); put_pkt(1, 1, '{64, 0, 0}, '{2, 0, 0});
        put_pkt(0, 2, '{8, 9, 0}, '{1, 3, 0}); put_pkt(0, 1, '{61, 0, 0}, '{0, 0, 0});
        take(0); take(1); poll(1, 1);
        check_frames("R3 priority"); check_own("R6");

        // R3: urgent poll during a long bulk frame must not preempt
        put_pkt(1, 1, '{200, 0, 0}, '{0, 0, 0}); put_pkt(0, 1, '{20, 0, 0}, '{1, 0, 0});
        take(1); take(0); poll(0, 1);
        t = 0;
        while (cur_len == 0 && t < 5000) begin @(negedge clk); t++; end
        poll(1, 0);
        check_frames("R3 no preempt"); check_own("R6");

        // R8: descriptor placed without a poll stays unsent
        put_pkt(1, 1, '{16, 0, 0}, '{0, 0, 0});
        repeat (300) @(negedge clk);
        chk(got_l.size() == 0 && cur_len == 0, "R8 no output before poll", got_l.size(), 0);
        take(1); poll(0, 1);
        check_frames("R8 resume"); check_own("R6");

        // R7: bulk ring crosses its end-of-ring slot
        for (int k = 0; k < 4; k++) put_pkt(1, 1, '{12 + k, 0, 0}, '{k % 4, 0, 0});
        take(1); poll(0, 1);
        check_frames("R7 wrap"); check_own("R7");

        // R9: buffer length below 4
        e0 = errs;
        put_desc(1, OWN | FS | LS, 2, 32'h1000); poll(0, 1);
        repeat (300) @(negedge clk);
        chk(errs - e0 == 1, "R9 short buffer error", errs - e0, 1);
        chk(got_l.size() == 0 && cur_len == 0, "R9 short buffer silent", got_l.size(), 0);
        check_own("R9");

        // R9: first descriptor lacks first-fragment flag
        e0 = errs;
        put_desc(1, OWN | LS, 8, 32'h1000); poll(0, 1);
        repeat (300) @(negedge clk);
        chk(errs - e0 == 1, "R9 missing first flag", errs - e0, 1);
        chk(got_l.size() == 0 && cur_len == 0, "R9 missing first silent", got_l.size(), 0);
        check_own("R9");

        // R9: misaligned base, then recovery
        e0 = errs;
        @(negedge clk); lo_base = LB + 32'h4;
        put_pkt(1, 1, '{12, 0, 0}, '{1, 0, 0}); poll(0, 1);
        repeat (200) @(negedge clk);
        chk(errs - e0 == 1, "R9 misaligned base error", errs - e0, 1);
        chk(got_l.size() == 0 && cur_len == 0, "R9 misaligned silent", got_l.size(), 0);
        lo_base = LB; take(1); poll(0, 1);
        check_frames("R9 recover"); check_own("R6");

        // R2 R4 R5: random batches on both rings
        for (int bt = 0; bt < 8; bt++) begin
            for (int r = 0; r < 2; r++) begin
                int np = 1 + $urandom % 3;
                for (int p = 0; p < np; p++) begin
                    int nf = 1 + $urandom % 2;
                    int ls [3], os [3];
                    for (int f = 0; f < 3; f++) begin ls[f] = 4 + $urandom % 37; os[f] = $urandom % 4; end
                    put_pkt(r, nf, ls, os);
                end
            end
            take(0); take(1); poll(1, 1);
            check_frames("R2 random"); check_own("R6");
        end

        chk(errs == 3, "R9 total error pulses", errs, 3);
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule